// File: doc/BRIEF.md
# NAND Flash Bus Sequencer

This block sits between a simple host request port and an asynchronous NAND flash bus that is 8 or 16 bits wide. The host hands over one operation at a time with a valid/ready handshake. Each operation is a command-latch write, an address-latch write, a data write or a data read. The block raises the matching latch-enable line and shapes the write or read strobe with low and high widths set in clock cycles. It then reports completion with a one-cycle done pulse that carries the read data and a status code.

When asked, an operation ends with a wait on the flash ready/busy line. The polarity of that line is selectable and the wait is bounded by a programmable timeout. A fixed chip delay replaces the polling when no ready line is in use. The block also owns the single write-protect output that all chip selects share.

After reset the block runs a power-up sequence on its own. It releases write protect, sends the reset command byte, and holds off the host for a settling interval before it accepts the first request.

Top module: `nand_bus_seq`

## Requirements
- R1: While `rst` is high, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1; `nand_cle`, `nand_ale`, `nand_dq_oe`, `nand_wp_n`, `req_ready` and `done` are 0.
- R2: After reset the block drives `nand_wp_n` to 1 before its first write strobe. That first strobe carries 0xFF on the low byte with `nand_cle` high. `req_ready` then stays low for CLK_MHZ*RESET_US cycles after the strobe ends.
- R3: Operation codes are 00 command, 01 address, 10 data write and 11 data read. A command asserts `nand_cle` only and an address asserts `nand_ale` only. Data writes and reads assert neither. A read never drives the bus.
- R4: A request with `req_nocmd`=1 updates `nand_cle`/`nand_ale` to the selection of its code. It produces no write or read strobe, and `done` with status 00 appears right after the accepting edge.
- R5: A write strobe is low for WE_LO cycles and high for WE_HI cycles, and a read strobe is low for RE_LO and high for RE_HI. Without a wait, `done` rises 1+WE_LO+WE_HI (or 1+RE_LO+RE_HI) edges after acceptance. Read data is captured at the edge where `nand_re_n` rises.
- R6: `cfg_bus_w`=01 selects 16-bit data transfers; any other code selects 8-bit, with the upper byte driven and returned as 0. Command and address bytes always use only the low byte.
- R7: With `req_wait`=1 and `cfg_wait_en`=1, `done` carries status 00 once the synchronised `nand_rb` equals `cfg_wait_pol`. A value of 1 means ready-high and 0 means ready-low. Ready seen on the first poll cycle gives `done` 2 edges after the strobe ends.
- R8: If the ready level is not reached within `cfg_timeout` poll cycles, `done` carries status 01. This happens cfg_timeout+2 edges after the strobe ends.
- R9: With `req_wait`=1 and `cfg_wait_en`=0, `done` comes CLK_MHZ*CHIP_DELAY_US+1 edges after the strobe ends, with status 00, whatever `nand_rb` does.
- R10: Outside the power-up sequence, a `wp_wr` pulse sets `nand_wp_n` to `wp_val` on the next edge. 0 means protected and 1 means writable.
- R11: `nand_cle` and `nand_ale` are never both high, and the two strobes are never low together. `nand_dq_oe` is high while `nand_we_n` is low and low while `nand_re_n` is low.
- R12: `req_ready` is low while any strobe is low, so only one operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 2 | Operation code |
| req_nocmd | input | 1 | Change latch selection only, send nothing |
| req_wait | input | 1 | Wait for ready (or chip delay) after the strobe |
| req_data | input | 16 | Byte or word to send |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 00 ok, 01 timeout |
| done_data | output | 16 | Read data (0 for other operations) |
| cfg_bus_w | input | 2 | Bus width code, 01 = 16-bit |
| cfg_wait_en | input | 1 | Ready line in use |
| cfg_wait_pol | input | 1 | Ready level of the ready/busy line |
| cfg_timeout | input | TO_W | Poll cycles before timeout |
| wp_wr | input | 1 | Update write protect |
| wp_val | input | 1 | New write-protect control bit |
| nand_ce_n | output | 1 | Chip enable, low active |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, low active |
| nand_re_n | output | 1 | Read strobe, low active |
| nand_wp_n | output | 1 | Write protect, low = protected |
| nand_dq_o | output | 16 | Bus output data |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 16 | Bus input data |
| nand_rb | input | 1 | Ready/busy line from the flash |

## Verification
The checker assumes the host holds `req_valid` and its fields steady until acceptance. It also assumes configuration inputs change only while the block is idle, because latch outputs and strobe widths are judged against a stable selection. The bench drives every request and configuration change at the falling edge, only when `req_ready` is high, and always between operations. `nand_rb` and `nand_dq_i` are treated as asynchronous to the block, so the ready/busy line is moved at arbitrary falling edges. The read bus holds one fixed pattern for the whole run.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int DQ_W   = 16;
    localparam int HALF_W = 8;

    typedef enum logic [1:0] {
        OP_CMD  = 2'b00,
        OP_ADDR = 2'b01,
        OP_WR   = 2'b10,
        OP_RD   = 2'b11
    } nand_op_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'b00,
        ST_TOUT = 2'b01
    } nand_st_e;

    typedef enum logic [3:0] {
        S_INIT_WP,
        S_SETUP,
        S_WLO,
        S_WHI,
        S_RLO,
        S_RHI,
        S_WAIT,
        S_INIT_WAIT,
        S_IDLE
    } seq_state_e;

    typedef struct packed {
        logic cle;
        logic ale;
    } latch_sel_t;

    typedef struct packed {
        nand_op_e              op;
        logic                  nocmd;
        logic                  wait_rdy;
        logic [DQ_W-1:0]       data;
    } host_req_t;

    function automatic latch_sel_t sel_for_op(nand_op_e op);
        latch_sel_t s;
        s.cle = (op == OP_CMD);
        s.ale = (op == OP_ADDR);
        return s;
    endfunction

    function automatic logic bus_is_wide(logic [1:0] code);
        return code == 2'b01;
    endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync (
    input  logic clk,
    input  logic rst,
    input  logic rb_async,
    input  logic ready_level,
    output logic ready
);
    logic [1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= 2'b00;
        end else begin
            stage <= {stage[0], rb_async};
        end
    end

    assign ready = (stage[1] == ready_level);
endmodule

// File: rtl/nand_wait_unit.sv
module nand_wait_unit #(
    parameter int DELAY_CYC = 50,
    parameter int TO_W      = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            poll_en,
    input  logic            ready,
    input  logic [TO_W-1:0] limit,
    output logic            fin,
    output logic            tout
);
    localparam int DW  = $clog2(DELAY_CYC + 1);
    localparam int WCW = ((DW > TO_W) ? DW : TO_W) + 1;

    logic           active;
    logic [WCW-1:0] cnt;
    logic [WCW-1:0] limit_ext;

    assign limit_ext = {{(WCW-TO_W){1'b0}}, limit};

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            fin    <= 1'b0;
            tout   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
                tout   <= 1'b0;
            end else if (active) begin
                if (poll_en) begin
                    if (ready) begin
                        fin    <= 1'b1;
                        tout   <= 1'b0;
                        active <= 1'b0;
                    end else if (cnt == limit_ext) begin
                        fin    <= 1'b1;
                        tout   <= 1'b1;
                        active <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    if (cnt == WCW'(DELAY_CYC - 1)) begin
                        fin    <= 1'b1;
                        tout   <= 1'b0;
                        active <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/nand_dq_path.sv
module nand_dq_path
    import nand_seq_pkg::*;
(
    input  logic            wide,
    input  nand_op_e        op,
    input  logic [DQ_W-1:0] wdata,
    input  logic [DQ_W-1:0] rd_raw,
    output logic [DQ_W-1:0] drive,
    output logic [DQ_W-1:0] rd_fmt
);
    logic data_wide;

    always_comb begin
        data_wide = wide && (op == OP_WR);
        if (data_wide) begin
            drive = wdata;
        end else begin
            drive = {{(DQ_W-HALF_W){1'b0}}, wdata[HALF_W-1:0]};
        end
        if (wide) begin
            rd_fmt = rd_raw;
        end else begin
            rd_fmt = {{(DQ_W-HALF_W){1'b0}}, rd_raw[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
    import nand_seq_pkg::*;
#(
    parameter int WE_LO         = 3,
    parameter int WE_HI         = 2,
    parameter int RE_LO         = 4,
    parameter int RE_HI         = 2,
    parameter int CLK_MHZ       = 125,
    parameter int CHIP_DELAY_US = 50,
    parameter int RESET_US      = 1000,
    parameter int TO_W          = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic                 req_nocmd,
    input  logic                 req_wait,
    input  logic [DQ_W-1:0]      req_data,
    output logic                 done,
    output logic [1:0]           done_status,
    output logic [DQ_W-1:0]      done_data,
    input  logic [1:0]           cfg_bus_w,
    input  logic                 cfg_wait_en,
    input  logic                 cfg_wait_pol,
    input  logic [TO_W-1:0]      cfg_timeout,
    input  logic                 wp_wr,
    input  logic                 wp_val,
    output logic                 nand_ce_n,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_we_n,
    output logic                 nand_re_n,
    output logic                 nand_wp_n,
    output logic [DQ_W-1:0]      nand_dq_o,
    output logic                 nand_dq_oe,
    input  logic [DQ_W-1:0]      nand_dq_i,
    input  logic                 nand_rb
);
    localparam int DELAY_CYC = CLK_MHZ * CHIP_DELAY_US;
    localparam int RESET_CYC = CLK_MHZ * RESET_US;
    localparam int CNT_W     = $clog2(RESET_CYC + WE_LO + WE_HI + RE_LO + RE_HI + 2) + 1;
    localparam logic [7:0] RESET_CMD = 8'hFF;

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             in_init;
    logic             do_wait;
    logic             is_read;
    logic             wp_bit;
    host_req_t        req;
    latch_sel_t       req_sel;
    logic [DQ_W-1:0]  drive_word;
    logic [DQ_W-1:0]  rd_word;
    logic             rdy_now;
    logic             wait_start;
    logic             wait_fin;
    logic             wait_tout;

    assign req.op       = nand_op_e'(req_op);
    assign req.nocmd    = req_nocmd;
    assign req.wait_rdy = req_wait;
    assign req.data     = req_data;
    assign req_sel      = sel_for_op(req.op);
    assign req_ready    = (state == S_IDLE);
    assign nand_wp_n    = wp_bit;

    nand_dq_path u_dq (
        .wide   (bus_is_wide(cfg_bus_w)),
        .op     (req.op),
        .wdata  (req.data),
        .rd_raw (nand_dq_i),
        .drive  (drive_word),
        .rd_fmt (rd_word)
    );

    nand_rb_sync u_rb (
        .clk         (clk),
        .rst         (rst),
        .rb_async    (nand_rb),
        .ready_level (cfg_wait_pol),
        .ready       (rdy_now)
    );

    assign wait_start = do_wait && (cnt == '0) && !in_init &&
                        ((state == S_WHI) || (state == S_RHI));

    nand_wait_unit #(
        .DELAY_CYC (DELAY_CYC),
        .TO_W      (TO_W)
    ) u_wait (
        .clk     (clk),
        .rst     (rst),
        .start   (wait_start),
        .poll_en (cfg_wait_en),
        .ready   (rdy_now),
        .limit   (cfg_timeout),
        .fin     (wait_fin),
        .tout    (wait_tout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_INIT_WP;
            cnt         <= '0;
            in_init     <= 1'b0;
            do_wait     <= 1'b0;
            is_read     <= 1'b0;
            wp_bit      <= 1'b0;
            nand_ce_n   <= 1'b1;
            nand_cle    <= 1'b0;
            nand_ale    <= 1'b0;
            nand_we_n   <= 1'b1;
            nand_re_n   <= 1'b1;
            nand_dq_o   <= '0;
            nand_dq_oe  <= 1'b0;
            done        <= 1'b0;
            done_status <= ST_OK;
            done_data   <= '0;
        end else begin
            done <= 1'b0;
            if (wp_wr && !in_init && (state != S_INIT_WP)) begin
                wp_bit <= wp_val;
            end
            case (state)
                S_INIT_WP: begin
                    wp_bit     <= 1'b1;
                    nand_ce_n  <= 1'b0;
                    nand_cle   <= 1'b1;
                    nand_ale   <= 1'b0;
                    nand_dq_o  <= {{(DQ_W-HALF_W){1'b0}}, RESET_CMD};
                    nand_dq_oe <= 1'b1;
                    in_init    <= 1'b1;
                    do_wait    <= 1'b0;
                    is_read    <= 1'b0;
                    state      <= S_SETUP;
                end
                S_SETUP: begin
                    if (is_read) begin
                        nand_re_n <= 1'b0;
                        cnt       <= CNT_W'(RE_LO - 1);
                        state     <= S_RLO;
                    end else begin
                        nand_we_n <= 1'b0;
                        cnt       <= CNT_W'(WE_LO - 1);
                        state     <= S_WLO;
                    end
                end
                S_WLO: begin
                    if (cnt == '0) begin
                        nand_we_n <= 1'b1;
                        cnt       <= CNT_W'(WE_HI - 1);
                        state     <= S_WHI;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_WHI: begin
                    if (cnt == '0) begin
                        nand_dq_oe <= 1'b0;
                        if (in_init) begin
                            cnt   <= CNT_W'(RESET_CYC - 1);
                            state <= S_INIT_WAIT;
                        end else if (do_wait) begin
                            state <= S_WAIT;
                        end else begin
                            done        <= 1'b1;
                            done_status <= ST_OK;
                            state       <= S_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_RLO: begin
                    if (cnt == '0) begin
                        nand_re_n <= 1'b1;
                        done_data <= rd_word;
                        cnt       <= CNT_W'(RE_HI - 1);
                        state     <= S_RHI;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_RHI: begin
                    if (cnt == '0) begin
                        if (do_wait) begin
                            state <= S_WAIT;
                        end else begin
                            done        <= 1'b1;
                            done_status <= ST_OK;
                            state       <= S_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_WAIT: begin
                    if (wait_fin) begin
                        done        <= 1'b1;
                        done_status <= wait_tout ? ST_TOUT : ST_OK;
                        state       <= S_IDLE;
                    end
                end
                S_INIT_WAIT: begin
                    if (cnt == '0) begin
                        in_init  <= 1'b0;
                        nand_cle <= 1'b0;
                        state    <= S_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_IDLE: begin
                    if (req_valid) begin
                        nand_cle  <= req_sel.cle;
                        nand_ale  <= req_sel.ale;
                        done_data <= '0;
                        if (req.nocmd) begin
                            done        <= 1'b1;
                            done_status <= ST_OK;
                        end else begin
                            nand_dq_o  <= drive_word;
                            nand_dq_oe <= (req.op != OP_RD);
                            is_read    <= (req.op == OP_RD);
                            do_wait    <= req.wait_rdy;
                            state      <= S_SETUP;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nand_bus_seq_chk.sv
module nand_bus_seq_chk #(
    parameter int WE_LO = 3
) (
    input logic clk,
    input logic rst,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic dq_oe,
    input logic req_ready
);
    logic [7:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
        end else if (!we_n) begin
            lo_cnt <= lo_cnt + 1'b1;
        end else begin
            lo_cnt <= '0;
        end
    end

    // R11
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    // R11
    drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> dq_oe);

    // R3
    read_data_path_chk: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> (!dq_oe && !cle && !ale));

    // R12
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> !req_ready);

    // R5
    we_low_width_chk: assert property (@(posedge clk) disable iff (rst)
        (we_n && (lo_cnt != 8'd0)) |-> (lo_cnt == 8'(WE_LO)));
endmodule

bind nand_bus_seq nand_bus_seq_chk #(.WE_LO(WE_LO)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .dq_oe     (nand_dq_oe),
    .req_ready (req_ready)
);

// File: tb/test_nand_bus_seq.sv
`timescale 1ns/1ps
module test_nand_bus_seq;
    localparam int WLO = 3;
    localparam int WHI = 2;
    localparam int RLO = 4;
    localparam int RHI = 2;
    localparam int MHZ = 1;
    localparam int DLY = MHZ * 50;
    localparam int RSTW = MHZ * 1000;
    localparam logic [15:0] RD_PAT = 16'hA55A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'b00;
    logic req_nocmd = 1'b0;
    logic req_wait = 1'b0;
    logic [15:0] req_data = '0;
    logic done;
    logic [1:0] done_status;
    logic [15:0] done_data;
    logic [1:0] cfg_bus_w = 2'b00;
    logic cfg_wait_en = 1'b0;
    logic cfg_wait_pol = 1'b1;
    logic [15:0] cfg_timeout = 16'd200;
    logic wp_wr = 1'b0;
    logic wp_val = 1'b0;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_dq_oe;
    logic [15:0] nand_dq_o;
    logic [15:0] nand_dq_i = RD_PAT;
    logic nand_rb = 1'b0;

    always #4 clk = ~clk;

    nand_bus_seq #(
        .WE_LO(WLO), .WE_HI(WHI), .RE_LO(RLO), .RE_HI(RHI),
        .CLK_MHZ(MHZ), .CHIP_DELAY_US(50), .RESET_US(1000), .TO_W(16)
    ) i_nand_bus_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_nocmd(req_nocmd), .req_wait(req_wait), .req_data(req_data),
        .done(done), .done_status(done_status), .done_data(done_data),
        .cfg_bus_w(cfg_bus_w), .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol),
        .cfg_timeout(cfg_timeout), .wp_wr(wp_wr), .wp_val(wp_val),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
        .nand_rb(nand_rb)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // captured per operation
    int lat, we_cnt, re_cnt;
    logic c_cle, c_ale, c_oe, r_cle, r_ale;
    logic [15:0] c_dq;

    // op(2) nocmd(1) width(2) data(16) cle(1) ale(1) dq(16) pulse(2: 1 WE, 2 RE, 0 none) rd(16)
    localparam int NV = 12;
    localparam logic [56:0] VEC [NV] = '{
        {2'b00, 1'b0, 2'b00, 16'h1270, 1'b1, 1'b0, 16'h0070, 2'd1, 16'h0000},
        {2'b01, 1'b0, 2'b01, 16'hBEEF, 1'b0, 1'b1, 16'h00EF, 2'd1, 16'h0000},
        {2'b10, 1'b0, 2'b01, 16'hBEEF, 1'b0, 1'b0, 16'hBEEF, 2'd1, 16'h0000},
        {2'b10, 1'b0, 2'b00, 16'hBEEF, 1'b0, 1'b0, 16'h00EF, 2'd1, 16'h0000},
        {2'b10, 1'b0, 2'b10, 16'h1234, 1'b0, 1'b0, 16'h0034, 2'd1, 16'h0000},
        {2'b11, 1'b0, 2'b01, 16'h0000, 1'b0, 1'b0, 16'h0000, 2'd2, 16'hA55A},
        {2'b11, 1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h005A},
        {2'b11, 1'b0, 2'b11, 16'h0000, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h005A},
        {2'b00, 1'b1, 2'b00, 16'h0090, 1'b1, 1'b0, 16'h0000, 2'd0, 16'h0000},
        {2'b01, 1'b1, 2'b00, 16'h0011, 1'b0, 1'b1, 16'h0000, 2'd0, 16'h0000},
        {2'b11, 1'b1, 2'b00, 16'h0000, 1'b0, 1'b0, 16'h0000, 2'd0, 16'h0000},
        {2'b10, 1'b0, 2'b01, 16'h0001, 1'b0, 1'b0, 16'h0001, 2'd1, 16'h0000}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sample_cycle();
        if (!nand_we_n) begin
            we_cnt++; c_cle = nand_cle; c_ale = nand_ale; c_dq = nand_dq_o; c_oe = nand_dq_oe;
        end
        if (!nand_re_n) begin
            re_cnt++; r_cle = nand_cle; r_ale = nand_ale;
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic nc, input logic wt, input logic [15:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = op; req_nocmd = nc; req_wait = wt; req_data = d; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; we_cnt = 0; re_cnt = 0;
        c_cle = 0; c_ale = 0; c_oe = 0; c_dq = '0; r_cle = 0; r_ale = 0;
        sample_cycle();
        while (!done && lat < 5000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            sample_cycle();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int idx;
        int first_we;
        int last_we;
        logic wp_at_we, cle_at_we;
        logic [15:0] dq_at_we;

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(nand_ce_n && nand_we_n && nand_re_n, "R1", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        chk(!nand_cle && !nand_ale && !nand_dq_oe && !nand_wp_n, "R1",
            {nand_cle, nand_ale, nand_dq_oe, nand_wp_n}, 4'b0000);
        chk(!req_ready && !done, "R1", {req_ready, done}, 2'b00);
        rst = 1'b0;

        // R2 power-up sequence
        idx = 0; first_we = -1; last_we = -1;
        wp_at_we = 0; cle_at_we = 0; dq_at_we = '0;
        while (!req_ready && idx < 5000) begin
            @(negedge clk);
            idx++;
            if (!nand_we_n) begin
                if (first_we < 0) begin
                    first_we = idx; wp_at_we = nand_wp_n; cle_at_we = nand_cle; dq_at_we = nand_dq_o;
                end
                last_we = idx;
            end
        end
        chk(first_we > 0 && wp_at_we, "R2", {31'd0, wp_at_we}, 1);
        chk(cle_at_we && dq_at_we == 16'h00FF, "R2", {15'd0, cle_at_we, dq_at_we}, {15'd0, 1'b1, 16'h00FF});
        chk((idx - last_we) >= RSTW && (idx - last_we) <= RSTW + 4, "R2", idx - last_we, RSTW);
        chk(nand_wp_n == 1'b1, "R2", nand_wp_n, 1);

        // table walk: R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            logic [56:0] e;
            int exp_lat;
            e = VEC[v];
            cfg_bus_w = e[53:52];
            run_op(e[56:55], e[54], 1'b0, e[51:36]);
            exp_lat = (e[17:16] == 2'd1) ? (1 + WLO + WHI) : (e[17:16] == 2'd2) ? (1 + RLO + RHI) : 0;
            chk(lat == exp_lat, "R5", lat, exp_lat);
            chk(done_status == 2'b00, "R5", done_status, 0);
            if (e[17:16] == 2'd1) begin
                chk(we_cnt == WLO && re_cnt == 0, "R5", we_cnt, WLO);
                chk(c_cle == e[35] && c_ale == e[34] && c_oe, "R3", {c_cle, c_ale, c_oe}, {e[35], e[34], 1'b1});
                chk(c_dq == e[33:18], "R6", c_dq, e[33:18]);
            end else if (e[17:16] == 2'd2) begin
                chk(re_cnt == RLO && we_cnt == 0, "R5", re_cnt, RLO);
                chk(!r_cle && !r_ale, "R3", {r_cle, r_ale}, 0);
                chk(done_data == e[15:0], "R6", done_data, e[15:0]);
            end else begin
                chk(we_cnt == 0 && re_cnt == 0, "R4", {we_cnt[15:0], re_cnt[15:0]}, 0);
                chk(nand_cle == e[35] && nand_ale == e[34], "R4", {nand_cle, nand_ale}, {e[35], e[34]});
            end
        end

        // R9 fixed chip delay, rb ignored
        cfg_bus_w = 2'b00; cfg_wait_en = 1'b0; cfg_wait_pol = 1'b1; nand_rb = 1'b0;
        run_op(2'b00, 1'b0, 1'b1, 16'h0030);
        chk(lat == 1 + WLO + WHI + DLY + 1, "R9", lat, 1 + WLO + WHI + DLY + 1);
        chk(done_status == 2'b00, "R9", done_status, 0);

        // R7 active-low ready already present
        cfg_wait_en = 1'b1; cfg_wait_pol = 1'b0; nand_rb = 1'b0; cfg_timeout = 16'd30;
        repeat (3) @(negedge clk);
        run_op(2'b00, 1'b0, 1'b1, 16'h0070);
        chk(lat == 1 + WLO + WHI + 2, "R7", lat, 1 + WLO + WHI + 2);
        chk(done_status == 2'b00, "R7", done_status, 0);

        // R7 active-high ready arriving during the poll
        cfg_wait_pol = 1'b1; cfg_timeout = 16'd200;
        fork
            run_op(2'b10, 1'b0, 1'b1, 16'h0042);
            begin repeat (20) @(negedge clk); nand_rb = 1'b1; end
        join
        chk(done_status == 2'b00, "R7", done_status, 0);
        chk(lat > 1 + WLO + WHI + 2 && lat < 200, "R7", lat, 20);

        // R8 timeout, active-high polarity, line stays busy
        nand_rb = 1'b0; cfg_timeout = 16'd30;
        repeat (3) @(negedge clk);
        run_op(2'b00, 1'b0, 1'b1, 16'h0070);
        chk(done_status == 2'b01, "R8", done_status, 1);
        chk(lat == 1 + WLO + WHI + 2 + 30, "R8", lat, 1 + WLO + WHI + 2 + 30);

        // R8 timeout, active-low polarity with line high
        cfg_wait_pol = 1'b0; nand_rb = 1'b1;
        repeat (3) @(negedge clk);
        run_op(2'b11, 1'b0, 1'b1, 16'h0000);
        chk(done_status == 2'b01, "R8", done_status, 1);

        // R10 write-protect control
        @(negedge clk);
        wp_wr = 1'b1; wp_val = 1'b0;
        @(negedge clk);
        wp_wr = 1'b0;
        chk(nand_wp_n == 1'b0, "R10", nand_wp_n, 0);
        wp_wr = 1'b1; wp_val = 1'b1;
        @(negedge clk);
        wp_wr = 1'b0;
        chk(nand_wp_n == 1'b1, "R10", nand_wp_n, 1);

        // R11 R12 end-of-run bus state
        chk(req_ready && nand_we_n && nand_re_n && !nand_dq_oe, "R12",
            {req_ready, nand_we_n, nand_re_n, nand_dq_oe}, 4'b1110);
        chk(!(nand_cle && nand_ale), "R11", {nand_cle, nand_ale}, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule